// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block moves a low-power DRAM into self refresh when the system asks it to sleep and brings it back when the system asks it to wake. Before entry it asks the periodic refresh sequencer for one CAS-before-RAS refresh. As soon as that refresh completes, it takes over the strobes. It drops CAS, then RAS, and holds RAS low for at least the self-refresh minimum. On wake it raises both strobes and waits out the longer self-refresh precharge. It then asks for one more CBR refresh before handing the strobes back.

A wake request that comes too early is remembered and served once the minimum low time has passed. This keeps RAS low time out of the window in which the memory is changing modes. After an exit, the block counts refreshes that the sequencer reports while awake. A sleep request is held back until every row has been refreshed once. The same holds after reset. The status output tells the access controller whether it is awake, entering, asleep or exiting. Memory requests may be issued only while it is awake.

All durations are parameters in clock cycles. The defaults suit a 100 MHz clock: 100 µs of hold, 110 ns of precharge and 4096 rows.

Top module: `dram_sleep_ctrl`

## Requirements
- R1: While reset is held, pwr_state is 0 (awake), ras_n and cas_n are 1, and ref_req and pins_own are 0.
- R2: A sleep request accepted while awake sets pwr_state to 1 (entering) and asserts ref_req in the next cycle. ref_req stays high with cas_n at 1 until ref_done is seen.
- R3: In the cycle after the pre-entry ref_done, cas_n goes low with ras_n still high and pins_own high. CAS stays low alone for CSR_CYC cycles, and then ras_n goes low. CAS always falls before RAS.
- R4: While asleep, pwr_state is 2, ras_n and cas_n are both low, pins_own is 1 and ref_req is 0.
- R5: A wake request that arrives before the minimum hold has passed is latched, even if it is only a one-cycle pulse. RAS then stays low for exactly HOLD_CYC cycles and never fewer.
- R6: A wake request after the minimum hold starts the exit at the next clock edge: ras_n goes high and pwr_state becomes 3.
- R7: On exit, ras_n and cas_n rise together and pwr_state is 3. Both strobes stay high, with ref_req low, for PRECH_CYC cycles. ref_req then rises and pins_own drops.
- R8: The post-exit ref_done returns pwr_state to 0 and clears the row-refresh count. A sleep request right after that exit is not served.
- R9: While awake, each ref_done counts one refreshed row, up to ROWS. A sleep request is held until the count reaches ROWS. Entry begins one cycle after the count becomes full.
- R10: sleep_req has no effect outside the awake state. wake_req has no effect while awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter self refresh; a one-cycle pulse is enough |
| wake_req | input | 1 | Request to leave self refresh; a one-cycle pulse is enough |
| ref_done | input | 1 | One-cycle pulse from the refresh sequencer when a CBR refresh completes |
| ref_req | output | 1 | Asks the refresh sequencer for one CBR refresh |
| ras_n | output | 1 | Row strobe, active low, valid when pins_own is 1 |
| cas_n | output | 1 | Column strobe (both bytes), active low, valid when pins_own is 1 |
| pins_own | output | 1 | This block owns the strobes; address, OE and WE are don't-care and data is high-impedance |
| pwr_state | output | 2 | 0 awake, 1 entering, 2 asleep, 3 exiting |

## Verification
A wrong hold counter shows up as ras_n rising earlier or later than HOLD_CYC cycles after it fell. This is visible on the first sleep after the fault. A lost wake latch shows up as a stall, because pwr_state stays at 2. A row count that is not cleared, or that fills too early, shows up as pwr_state leaving 0 on a sleep request before ROWS refreshes have been reported. A skipped precharge shows up as ref_req rising in fewer than PRECH_CYC cycles after ras_n rises.

// File: rtl/dram_sleep_ctrl.sv
module dram_sleep_ctrl #(
  parameter int CSR_CYC   = 2,
  parameter int HOLD_CYC  = 10000,
  parameter int PRECH_CYC = 11,
  parameter int ROWS      = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       ref_done,
  output logic       ref_req,
  output logic       ras_n,
  output logic       cas_n,
  output logic       pins_own,
  output logic [1:0] pwr_state
);
  localparam int CMAX = (HOLD_CYC > PRECH_CYC) ? ((HOLD_CYC > CSR_CYC) ? HOLD_CYC : CSR_CYC)
                                               : ((PRECH_CYC > CSR_CYC) ? PRECH_CYC : CSR_CYC);
  localparam int CW = $clog2(CMAX + 1);
  localparam int RW = $clog2(ROWS + 1);
  localparam logic [CW-1:0] CSR_LAST   = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] PRECH_LAST = CW'(PRECH_CYC - 1);

  typedef enum logic [2:0] {AWAKE, PRE_REF, CAS_LEAD, HOLD, PRECH, POST_REF} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rows;
  logic          sleep_pend, wake_pend;
  logic          rows_full;

  assign rows_full = (rows == RW'(ROWS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= AWAKE;
      cnt        <= '0;
      rows       <= '0;
      sleep_pend <= 1'b0;
      wake_pend  <= 1'b0;
    end else begin
      case (st)
        AWAKE: begin
          if (ref_done && !rows_full) rows <= rows + 1'b1;
          if (sleep_req) sleep_pend <= 1'b1;
          if ((sleep_pend || sleep_req) && rows_full) begin
            st         <= PRE_REF;
            sleep_pend <= 1'b0;
            wake_pend  <= 1'b0;
          end
        end
        PRE_REF: begin
          if (wake_req) wake_pend <= 1'b1;
          if (ref_done) begin
            st  <= CAS_LEAD;
            cnt <= '0;
          end
        end
        CAS_LEAD: begin
          if (wake_req) wake_pend <= 1'b1;
          if (cnt == CSR_LAST) begin
            st  <= HOLD;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        HOLD: begin
          if (wake_req) wake_pend <= 1'b1;
          if (cnt == HOLD_LAST) begin
            if (wake_pend || wake_req) begin
              st        <= PRECH;
              cnt       <= '0;
              wake_pend <= 1'b0;
            end
          end else cnt <= cnt + 1'b1;
        end
        PRECH: begin
          if (cnt == PRECH_LAST) begin
            st  <= POST_REF;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        POST_REF: begin
          if (ref_done) begin
            st         <= AWAKE;
            rows       <= '0;
            sleep_pend <= 1'b0;
          end
        end
        default: st <= AWAKE;
      endcase
    end
  end

  assign ras_n    = (st != HOLD);
  assign cas_n    = !(st == CAS_LEAD || st == HOLD);
  assign pins_own = (st == CAS_LEAD || st == HOLD || st == PRECH);
  assign ref_req  = (st == PRE_REF || st == POST_REF);

  always_comb begin
    case (st)
      PRE_REF, CAS_LEAD: pwr_state = 2'd1;
      HOLD:              pwr_state = 2'd2;
      PRECH, POST_REF:   pwr_state = 2'd3;
      default:           pwr_state = 2'd0;
    endcase
  end
endmodule

// File: rtl/dram_sleep_ctrl_chk.sv
module dram_sleep_ctrl_chk #(
  parameter int HOLD_CYC  = 10000,
  parameter int PRECH_CYC = 11
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       ref_req,
  input logic [1:0] pwr_state,
  input logic       rows_full
);
  localparam int LW = $clog2(HOLD_CYC + 1);
  localparam int HW = $clog2(PRECH_CYC + 1);

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '0;
    end else begin
      if (!ras_n) low_cnt <= (low_cnt == LW'(HOLD_CYC)) ? low_cnt : low_cnt + 1'b1;
      else        low_cnt <= '0;
      if (ras_n)  high_cnt <= (high_cnt == HW'(PRECH_CYC)) ? high_cnt : high_cnt + 1'b1;
      else        high_cnt <= '0;
    end
  end

  assert_entry_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1 && cas_n) |-> ref_req);

  assert_cas_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

  assert_asleep_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2) |-> (!ras_n && !cas_n && !ref_req));

  assert_min_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_cnt >= LW'(HOLD_CYC)));

  assert_asleep_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2) |=> (pwr_state == 2'd2 || pwr_state == 2'd3));

  assert_exit_prech_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ref_req) && pwr_state == 2'd3) |-> (high_cnt >= HW'(PRECH_CYC)));

  assert_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 2'd0 && pwr_state == 2'd1) |-> $past(rows_full));
endmodule

bind dram_sleep_ctrl dram_sleep_ctrl_chk #(
  .HOLD_CYC (HOLD_CYC),
  .PRECH_CYC(PRECH_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .ref_req  (ref_req),
  .pwr_state(pwr_state),
  .rows_full(rows_full)
);

// File: tb/dram_sleep_ctrl_bench.sv
module dram_sleep_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CSR  = 2;
  localparam int HOLD = 20;
  localparam int PRE  = 3;
  localparam int NROW = 8;

  logic clk = 1'b0;
  logic rst_n, sleep_req, wake_req, ref_done;
  logic ref_req, ras_n, cas_n, pins_own;
  logic [1:0] pwr_state;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_sleep_ctrl #(.CSR_CYC(CSR), .HOLD_CYC(HOLD), .PRECH_CYC(PRE), .ROWS(NROW)) u_dram_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req), .ref_done(ref_done),
    .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n), .pins_own(pins_own), .pwr_state(pwr_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_done();
    ref_done = 1'b1; step(); ref_done = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0; ref_done = 1'b0;
    repeat (3) step();
    chk("R1 state", pwr_state, 0);
    chk("R1 ras_n", ras_n, 1);
    chk("R1 cas_n", cas_n, 1);
    chk("R1 ref_req", ref_req, 0);
    chk("R1 pins_own", pins_own, 0);
    rst_n = 1'b1; step();
  endtask

  task automatic t_holdoff();
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    chk("R9 held with no rows", pwr_state, 0);
    repeat (NROW - 1) pulse_done();
    step();
    chk("R9 held one row short", pwr_state, 0);
    pulse_done();
    chk("R9 not before full", pwr_state, 0);
    step();
    chk("R9 entry after full", pwr_state, 1);
    chk("R2 ref_req", ref_req, 1);
  endtask

  task automatic t_entry();
    repeat (3) step();
    chk("R2 ref_req held", ref_req, 1);
    chk("R2 cas_n high", cas_n, 1);
    pulse_done();
    chk("R3 cas_n low", cas_n, 0);
    chk("R3 ras_n high", ras_n, 1);
    chk("R3 pins_own", pins_own, 1);
    chk("R3 ref_req off", ref_req, 0);
    step();
    chk("R3 cas alone", ras_n, 1);
    step();
    chk("R4 ras_n", ras_n, 0);
    chk("R4 cas_n", cas_n, 0);
    chk("R4 state", pwr_state, 2);
  endtask

  task automatic t_early_wake();
    int lows = 1;
    wake_req = 1'b1; sleep_req = 1'b1; step(); wake_req = 1'b0; sleep_req = 1'b0;
    while (ras_n == 1'b0 && lows < HOLD + 10) begin
      lows++;
      step();
    end
    chk("R5 ras low cycles", lows, HOLD);
    chk("R7 state", pwr_state, 3);
    chk("R7 cas_n rises with ras", cas_n, 1);
    chk("R7 pins_own", pins_own, 1);
  endtask

  task automatic t_exit();
    repeat (PRE - 1) begin
      step();
      chk("R7 precharge no req", ref_req, 0);
    end
    step();
    chk("R7 ref_req", ref_req, 1);
    chk("R7 pins released", pins_own, 0);
    pulse_done();
    chk("R8 awake", pwr_state, 0);
  endtask

  task automatic t_ignore();
    repeat (NROW) pulse_done();
    repeat (3) step();
    chk("R10 sleep while asleep ignored", pwr_state, 0);
    wake_req = 1'b1; step(); wake_req = 1'b0;
    repeat (2) step();
    chk("R10 wake while awake ignored", pwr_state, 0);
    chk("R10 ras_n", ras_n, 1);
  endtask

  task automatic t_late_wake();
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    chk("R2 entering", pwr_state, 1);
    pulse_done(); step(); step();
    repeat (HOLD + 3) step();
    chk("R6 still asleep", pwr_state, 2);
    chk("R6 ras_n low", ras_n, 0);
    wake_req = 1'b1; step(); wake_req = 1'b0;
    chk("R6 ras_n high", ras_n, 1);
    chk("R6 exiting", pwr_state, 3);
    repeat (PRE) step();
    chk("R7 ref_req second", ref_req, 1);
    pulse_done();
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
    repeat (3) step();
    chk("R8 rows cleared on exit", pwr_state, 0);
  endtask

  initial begin
    t_reset();
    t_holdoff();
    t_entry();
    t_early_wake();
    t_exit();
    t_ignore();
    t_late_wake();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule